// File: doc/BRIEF.md
# Screen-Tile Triangle Distributor

This block sits between a primitive culling stage and a bank of rasterizer front ends. Screen space is cut into square tiles whose side is a power of two. The tiles are dealt to the front ends in a checkerboard pattern, so that neighbouring tiles belong to different front ends. For each incoming triangle the block works out the axis-aligned bounding box of its three vertices. From the lowest tile-index bit of the box's corners, and from whether the box crosses a tile boundary on each axis, it derives the set of front ends that own part of the box. That set always holds one, two or four front ends.

Before any copy is made, the block drops triangles with zero signed area and triangles whose three vertices all lie outside the screen rectangle. A one-cycle flag reports each dropped triangle. A surviving triangle is held in a single register. It is then offered to its front ends one at a time, in ascending index order, over one shared payload bus with a separate valid/ready pair for each front end. The upstream port stays stalled until the last copy has been taken. Each front end therefore receives its triangles in the order they arrived.

Top module: `tri_tile_distributor`

## Requirements
- R1: After a synchronous active-low reset, `in_ready` is 1, all `out_valid` bits are 0 and `cull_drop` is 0.
- R2: A vertex coordinate is an unsigned COORD_W-bit value with FRAC_W fraction bits. The pixel is coordinate >> FRAC_W, and the tile index is pixel >> TILE_LOG2. `in_tri` is packed as {y2,x2,y1,x1,y0,x0}, with x0 in the least significant bits. With four front ends, a tile is owned by index {ty[0],tx[0]}. With two front ends, it is owned by index tx[0]^ty[0].
- R3: The target set covers every owner of every tile in the bounding box, and nothing else. With four front ends this is one owner for a single tile, two owners for a box that spans tiles on one axis only, and all four for a box that spans tiles on both axes.
- R4: At most one `out_valid` bit is high in any cycle. The copies of one triangle are offered in ascending front-end index, with the next copy offered in the cycle after the previous one was accepted.
- R5: An offered copy keeps its `out_valid` bit and its `out_tri` value unchanged until the matching `out_ready` is high.
- R6: `in_ready` is low while any copy of the current triangle has not yet been accepted. It returns high in the cycle after the last copy is accepted.
- R7: A triangle whose signed doubled area (x1-x0)(y2-y0)-(x2-x0)(y1-y0) is zero is dropped without issuing any copy.
- R8: A triangle with every vertex outside the screen (pixel x >= SCREEN_W or pixel y >= SCREEN_H) is dropped. A triangle with at least one vertex on screen is issued.
- R9: A dropped triangle is accepted in the cycle it is presented. `cull_drop` is high in exactly that cycle, and no `out_valid` bit rises in the next cycle.
- R10: `out_tri` carries the accepted triangle bit for bit.
- R11: On each front-end port, triangles come out in the order they were accepted at the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Upstream triangle valid |
| in_ready | output | 1 | Distributor can accept a triangle |
| in_tri | input | 6*COORD_W | Triangle {y2,x2,y1,x1,y0,x0} |
| out_valid | output | NUM_FE | One valid per front end |
| out_ready | input | NUM_FE | One ready per front end |
| out_tri | output | 6*COORD_W | Shared payload for the offered copy |
| cull_drop | output | 1 | Pulses when a triangle is discarded |

## Verification
The embedded properties allow each front end to lower or raise its ready in any cycle, and they make no assumption about when upstream presents work. They do rely on reset being asserted from the first edge and on inputs that are never unknown. The stimulus drives every input from time zero and holds reset low for several cycles. It changes inputs only just after a rising edge, and it toggles each front end's ready at random. This makes held offers, back-to-back copies and a new triangle arriving right after a drop all occur.

// File: rtl/tri_dist_pkg.sv
// Package: shared types for the screen-tile triangle distributor.
// Assumes nothing beyond being compiled before the modules that import it.
package tri_dist_pkg;
    // How a bounding box crosses tile boundaries
    typedef enum logic [1:0] {
        SPAN_NONE = 2'd0,
        SPAN_X    = 2'd1,
        SPAN_Y    = 2'd2,
        SPAN_XY   = 2'd3
    } span_e;
endpackage

// File: rtl/tri_bbox_classify.sv
// Module: tri_bbox_classify
// Builds the bounding box of a triangle and turns it into a front-end target
// mask on a checkerboard tile layout. Purely combinational.
// Assumes NUM_FE is 1, 2 or 4 and TILE_LOG2 < COORD_W - FRAC_W.
module tri_bbox_classify
    import tri_dist_pkg::*;
#(
    parameter int COORD_W   = 16,
    parameter int FRAC_W    = 4,
    parameter int TILE_LOG2 = 5,
    parameter int NUM_FE    = 4
) (
    input  logic [6*COORD_W-1:0] tri_in,
    output logic [NUM_FE-1:0]    fe_mask
);
    localparam int IW = COORD_W - FRAC_W;

    logic [IW-1:0] px [3];
    logic [IW-1:0] py [3];
    logic [IW-1:0] xmin, xmax, ymin, ymax;
    logic [IW-1:0] txmin, txmax, tymin, tymax;
    logic          tx0, ty0;
    span_e         span;

    // Extract integer pixel positions of the three vertices
    always_comb begin
        for (int v = 0; v < 3; v++) begin
            px[v] = IW'(tri_in[(2*v)*COORD_W +: COORD_W] >> FRAC_W);
            py[v] = IW'(tri_in[(2*v+1)*COORD_W +: COORD_W] >> FRAC_W);
        end
    end

    // Reduce vertices to bounding-box extents
    always_comb begin
        xmin = px[0]; xmax = px[0];
        ymin = py[0]; ymax = py[0];
        for (int v = 1; v < 3; v++) begin
            if (px[v] < xmin) xmin = px[v];
            if (px[v] > xmax) xmax = px[v];
            if (py[v] < ymin) ymin = py[v];
            if (py[v] > ymax) ymax = py[v];
        end
    end

    // Tile indices and span classification
    always_comb begin
        txmin = xmin >> TILE_LOG2;
        txmax = xmax >> TILE_LOG2;
        tymin = ymin >> TILE_LOG2;
        tymax = ymax >> TILE_LOG2;
        tx0   = txmin[0];
        ty0   = tymin[0];
        span  = span_e'({tymin != tymax, txmin != txmax});
    end

    generate
        if (NUM_FE == 4) begin : g_four
            // Four owners: index {ty[0], tx[0]}
            always_comb begin
                unique case (span)
                    SPAN_NONE: fe_mask = 4'b0001 << {ty0, tx0};
                    SPAN_X:    fe_mask = ty0 ? 4'b1100 : 4'b0011;
                    SPAN_Y:    fe_mask = tx0 ? 4'b1010 : 4'b0101;
                    default:   fe_mask = 4'b1111;
                endcase
            end
        end else if (NUM_FE == 2) begin : g_two
            // Two owners: index tx[0]^ty[0]
            always_comb begin
                if (span == SPAN_NONE) fe_mask = 2'b01 << (tx0 ^ ty0);
                else                   fe_mask = 2'b11;
            end
        end else begin : g_one
            // Single owner takes everything
            always_comb fe_mask = '1;
        end
    endgenerate
endmodule

// File: rtl/tri_cull_check.sv
// Module: tri_cull_check
// Flags triangles with zero signed area or with all vertices off screen.
// Combinational. Assumes SCREEN_W and SCREEN_H fit in COORD_W - FRAC_W bits.
module tri_cull_check #(
    parameter int COORD_W  = 16,
    parameter int FRAC_W   = 4,
    parameter int SCREEN_W = 1920,
    parameter int SCREEN_H = 1080
) (
    input  logic [6*COORD_W-1:0] tri_in,
    output logic                 cull
);
    localparam int IW = COORD_W - FRAC_W;
    localparam int DW = COORD_W + 1;
    localparam int PW = 2 * DW;
    localparam logic [IW-1:0] SW_L = IW'(SCREEN_W);
    localparam logic [IW-1:0] SH_L = IW'(SCREEN_H);

    logic [COORD_W-1:0] cx [3];
    logic [COORD_W-1:0] cy [3];
    logic [2:0]         off;
    logic signed [DW-1:0] dx1, dy1, dx2, dy2;
    logic signed [PW-1:0] prod_a, prod_b, area2;

    // Split payload into coordinates
    always_comb begin
        for (int v = 0; v < 3; v++) begin
            cx[v] = tri_in[(2*v)*COORD_W +: COORD_W];
            cy[v] = tri_in[(2*v+1)*COORD_W +: COORD_W];
        end
    end

    // Per-vertex off-screen test
    always_comb begin
        for (int v = 0; v < 3; v++) begin
            off[v] = (IW'(cx[v] >> FRAC_W) >= SW_L) || (IW'(cy[v] >> FRAC_W) >= SH_L);
        end
    end

    // Doubled signed area from the edge cross product
    always_comb begin
        dx1    = $signed({1'b0, cx[1]}) - $signed({1'b0, cx[0]});
        dy1    = $signed({1'b0, cy[1]}) - $signed({1'b0, cy[0]});
        dx2    = $signed({1'b0, cx[2]}) - $signed({1'b0, cx[0]});
        dy2    = $signed({1'b0, cy[2]}) - $signed({1'b0, cy[0]});
        prod_a = PW'(dx1) * PW'(dy2);
        prod_b = PW'(dx2) * PW'(dy1);
        area2  = prod_a - prod_b;
    end

    // Final drop decision
    always_comb cull = (&off) || (area2 == '0);
endmodule

// File: rtl/tri_issue_seq.sv
// Module: tri_issue_seq
// Holds one triangle and a pending mask. It offers the triangle to the
// lowest pending front end and clears that bit on handshake.
// Assumes load is raised only while idle is high.
module tri_issue_seq #(
    parameter int NUM_FE = 4,
    parameter int DATA_W = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NUM_FE-1:0] load_mask,
    input  logic [DATA_W-1:0] load_tri,
    input  logic [NUM_FE-1:0] out_ready,
    output logic              idle,
    output logic [NUM_FE-1:0] out_valid,
    output logic [DATA_W-1:0] out_tri
);
    logic [NUM_FE-1:0] pending;
    logic [DATA_W-1:0] tri_q;
    logic [NUM_FE-1:0] fire;

    // Lowest pending bit is the current target
    always_comb begin
        out_valid = pending & (~pending + NUM_FE'(1));
        fire      = out_valid & out_ready;
        idle      = (pending == '0);
        out_tri   = tri_q;
    end

    // Pending-mask and payload registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
            tri_q   <= '0;
        end else if (load) begin
            pending <= load_mask;
            tri_q   <= load_tri;
        end else begin
            pending <= pending & ~fire;
        end
    end

    // R4: the next copy of the same triangle goes to a higher index
    assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|fire) && ((pending & ~fire) != '0)) |=> (out_valid > $past(out_valid)));

    // R5: an offered copy is held until taken
    assert_hold_offer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|out_valid) && !(|fire)) |=> ((out_valid == $past(out_valid)) && $stable(out_tri)));
endmodule

// File: rtl/tri_tile_distributor.sv
// Module: tri_tile_distributor
// Top level. Accepts one triangle at a time, drops degenerate or off-screen
// triangles, and issues the survivors to every front end that owns a tile
// under their bounding box, one copy per cycle in ascending index order.
// Assumes NUM_FE is 1, 2 or 4 and TILE_LOG2 gives a power-of-two tile.
module tri_tile_distributor #(
    parameter int COORD_W   = 16,
    parameter int FRAC_W    = 4,
    parameter int TILE_LOG2 = 5,
    parameter int NUM_FE    = 4,
    parameter int SCREEN_W  = 1920,
    parameter int SCREEN_H  = 1080
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [6*COORD_W-1:0] in_tri,
    output logic [NUM_FE-1:0]    out_valid,
    input  logic [NUM_FE-1:0]    out_ready,
    output logic [6*COORD_W-1:0] out_tri,
    output logic                 cull_drop
);
    localparam int DATA_W = 6 * COORD_W;

    logic [NUM_FE-1:0] mask;
    logic              cull;
    logic              idle;
    logic              accept;

    tri_bbox_classify #(
        .COORD_W(COORD_W), .FRAC_W(FRAC_W), .TILE_LOG2(TILE_LOG2), .NUM_FE(NUM_FE)
    ) u_classify (
        .tri_in (in_tri),
        .fe_mask(mask)
    );

    tri_cull_check #(
        .COORD_W(COORD_W), .FRAC_W(FRAC_W), .SCREEN_W(SCREEN_W), .SCREEN_H(SCREEN_H)
    ) u_cull (
        .tri_in(in_tri),
        .cull  (cull)
    );

    // Input handshake and drop flag
    always_comb begin
        in_ready  = idle;
        accept    = in_valid && in_ready;
        cull_drop = accept && cull;
    end

    tri_issue_seq #(
        .NUM_FE(NUM_FE), .DATA_W(DATA_W)
    ) u_issue (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept && !cull),
        .load_mask(mask),
        .load_tri (in_tri),
        .out_ready(out_ready),
        .idle     (idle),
        .out_valid(out_valid),
        .out_tri  (out_tri)
    );

    // R4: a single front end is offered a copy at a time
    assert_single_offer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid));

    // R6: no new triangle while copies remain
    assert_stall_while_issuing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_valid) |-> !in_ready);

    // R9: a dropped triangle never produces a copy
    assert_cull_no_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cull_drop |=> (out_valid == '0));

    // R10: a loaded triangle appears unchanged on the payload bus
    assert_payload_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cull) |=> (out_tri == $past(in_tri)));
endmodule

// File: tb/test_tri_tile_distributor.sv
module test_tri_tile_distributor;
    localparam int CW = 16;
    localparam int FR = 4;
    localparam int TL = 5;
    localparam int NF = 4;
    localparam int SW = 1920;
    localparam int SH = 1080;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [6*CW-1:0]   in_tri = '0;
    logic [NF-1:0]     out_valid;
    logic [NF-1:0]     out_ready = '0;
    logic [6*CW-1:0]   out_tri;
    logic              cull_drop;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_pend = 0;
    logic [6*CW-1:0] exp_tri = '0;
    logic accepted;
    logic [NF-1:0] prev_ov = '0;
    logic [NF-1:0] prev_rdy = '0;
    logic [6*CW-1:0] prev_tri = '0;
    string phase = "R2";

    always #2 clk = ~clk;

    tri_tile_distributor #(
        .COORD_W(CW), .FRAC_W(FR), .TILE_LOG2(TL), .NUM_FE(NF), .SCREEN_W(SW), .SCREEN_H(SH)
    ) i_tri_tile_distributor (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_tri(in_tri),
        .out_valid(out_valid), .out_ready(out_ready), .out_tri(out_tri), .cull_drop(cull_drop)
    );

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (%s) actual=%h expected=%h", tag, phase, act, exp);
        end
    endtask

    function automatic logic [6*CW-1:0] mk(int x0, int y0, int x1, int y1, int x2, int y2);
        logic [6*CW-1:0] t;
        t = {CW'(y2*16+8), CW'(x2*16+8), CW'(y1*16+8), CW'(x1*16+8), CW'(y0*16+8), CW'(x0*16+8)};
        return t;
    endfunction

    function automatic int crd(logic [6*CW-1:0] t, int idx);
        return int'(t[idx*CW +: CW]);
    endfunction

    // Reference drop rule
    function automatic bit ref_cull(logic [6*CW-1:0] t);
        longint ax, ay, bx, by;
        int offc = 0;
        for (int v = 0; v < 3; v++)
            if ((crd(t, 2*v) >> FR) >= SW || (crd(t, 2*v+1) >> FR) >= SH) offc++;
        ax = crd(t, 2) - crd(t, 0); ay = crd(t, 3) - crd(t, 1);
        bx = crd(t, 4) - crd(t, 0); by = crd(t, 5) - crd(t, 1);
        return (offc == 3) || (ax * by - bx * ay == 0);
    endfunction

    // Reference owner set: walk the tiles under the box
    function automatic int ref_mask(logic [6*CW-1:0] t);
        int xl = 1 << 30, xh = -1, yl = 1 << 30, yh = -1, m = 0;
        for (int v = 0; v < 3; v++) begin
            int px = crd(t, 2*v) >> FR;
            int py = crd(t, 2*v+1) >> FR;
            if (px < xl) xl = px;
            if (px > xh) xh = px;
            if (py < yl) yl = py;
            if (py > yh) yh = py;
        end
        for (int tx = xl >> TL; tx <= (xh >> TL) && tx <= (xl >> TL) + 1; tx++)
            for (int ty = yl >> TL; ty <= (yh >> TL) && ty <= (yl >> TL) + 1; ty++)
                m |= 1 << (((ty & 1) << 1) | (tx & 1));
        return m;
    endfunction

    // One clock of comparison and reference update
    task automatic tick();
        int ev;
        bit ec;
        @(negedge clk);
        ev = exp_pend & -exp_pend;
        ec = in_valid && (exp_pend == 0) && ref_cull(in_tri);
        chk("R6", 128'(in_ready), 128'(exp_pend == 0));
        chk("R3", 128'(out_valid), 128'(ev));
        chk(ref_cull(in_tri) ? "R9" : "R7", 128'(cull_drop), 128'(ec));
        if (ev != 0) chk("R10", 128'(out_tri), 128'(exp_tri));
        chk("R4", 128'($countones(out_valid) <= 1), 128'(1));
        if ((prev_ov & ~prev_rdy) != 0) begin
            chk("R5", 128'(out_valid), 128'(prev_ov));
            chk("R5", 128'(out_tri), 128'(prev_tri));
        end
        prev_ov = out_valid; prev_rdy = out_ready; prev_tri = out_tri;
        accepted = in_valid && (exp_pend == 0);
        if ((ev & int'(out_ready)) != 0) exp_pend &= ~ev;
        if (accepted && !ec) begin
            exp_pend = ref_mask(in_tri);
            exp_tri = in_tri;
        end
        @(posedge clk); #1;
    endtask

    task automatic send(logic [6*CW-1:0] t, int rdy_pct);
        in_valid = 1'b1; in_tri = t;
        do begin
            for (int i = 0; i < NF; i++) out_ready[i] = ($urandom_range(99) < rdy_pct);
            tick();
        end while (!accepted);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        out_ready = '1;
        while (exp_pend != 0) tick();
        tick();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 128'(in_ready), 128'(1));
        chk("R1", 128'(out_valid), 128'(0));
        chk("R1", 128'(cull_drop), 128'(0));
        @(posedge clk); #1;

        phase = "R2";
        send(mk(2, 2, 10, 3, 4, 12), 100);     drain();
        send(mk(40, 2, 50, 3, 45, 12), 100);   drain();
        send(mk(2, 40, 10, 41, 4, 50), 100);   drain();
        send(mk(40, 40, 50, 41, 45, 50), 40);  drain();
        phase = "R3";
        send(mk(20, 40, 70, 42, 30, 50), 100); drain();
        send(mk(40, 10, 45, 70, 50, 20), 50);  drain();
        send(mk(10, 10, 100, 20, 20, 100), 30); drain();
        phase = "R7";
        send(mk(5, 5, 10, 10, 20, 20), 100);   drain();
        phase = "R8";
        send(mk(2000, 5, 2010, 5, 2005, 1100), 100); drain();
        send(mk(1900, 1070, 2000, 1070, 1900, 1200), 100); drain();
        phase = "R9";
        send(mk(10, 10, 100, 20, 20, 100), 100);
        send(mk(7, 7, 7, 7, 30, 40), 100);
        send(mk(3, 3, 60, 3, 3, 60), 100);     drain();

        phase = "R11";
        for (int n = 0; n < 400; n++) begin
            int bx = $urandom_range(2100);
            int by = $urandom_range(1200);
            int s = $urandom_range(80);
            int xa = bx + $urandom_range(s), ya = by + $urandom_range(s);
            int xb = bx + $urandom_range(s), yb = by + $urandom_range(s);
            if ($urandom_range(9) == 0) begin xb = xa; yb = ya; end
            send(mk(bx, by, xa, ya, xb, yb), 60);
            if ($urandom_range(3) == 0) begin
                for (int i = 0; i < NF; i++) out_ready[i] = $urandom_range(1);
                tick();
            end
        end
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R6 watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule